// File: doc/BRIEF.md
# Microsecond Compare Timer

This peripheral keeps a 64-bit count that never stops and moves forward once every microsecond. A prescaler divides the system clock down to a one-cycle tick at 1 MHz, and each tick adds one to the count. Software reads the count through a simple 32-bit register bus as two words: a low word and a high word. The low word carries into the high word when it rolls over.

Four compare channels watch the low word of the count. When a tick moves the low word onto the value held in a channel's compare register, that channel's status flag is set and stays set. Each flag drives its own interrupt line. Software clears a flag by writing a one to its bit in the status register. Software can therefore poll the count, or it can load a compare value for a future microsecond and wait for the interrupt.

Top module: `usec_compare_timer`

## Requirements
- R1: With CLK_HZ/TICK_HZ = N, the count increases by exactly one every N clock cycles and holds its value between ticks.
- R2: After reset the count equals the RESET_COUNT parameter, all compare registers read 0, the status register reads 0 and every interrupt line is low.
- R3: Offset 0x04 reads count bits 31:0 and offset 0x08 reads count bits 63:32. A rollover of the low word from 0xFFFFFFFF to 0 adds one to the high word.
- R4: The compare registers for channels 0 to 3 sit at offsets 0x0C, 0x10, 0x14 and 0x18. Each one reads back the last value written to it.
- R5: Status bit n (offset 0x00, bit n) becomes 1 on the clock edge where a tick makes the low word equal to compare register n. It then stays 1 until software clears it.
- R6: A write to offset 0x00 clears status bit n when data bit n is 1. A data bit of 0 leaves status bit n unchanged.
- R7: If a match sets status bit n on the same edge as a write that clears it, the bit ends up as 1.
- R8: Interrupt line n always equals status bit n.
- R9: Writes to offsets 0x04 and 0x08 do not change the count.
- R10: Status bits 31:4 read 0. Offsets with no register, including 0x1C and addresses that are not word aligned, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Bus access strobe; a write takes effect when this is high together with bus_wr |
| bus_wr | input | 1 | Write select (1 = write) |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 4 | Per-channel interrupt lines |

## Verification
A compare match and a software clear of the same status bit can land on the same clock edge. The bench forces this case. It first tracks the tick phase by watching the low word change. It then loads a compare value that the next tick will reach, and issues the clearing write on exactly the clock edge of that tick. The result is judged by the interrupt line and the low word right after that edge: the flag must be set and the count must have just reached the compare value. A design in which the clear wins would leave the flag low.

// File: rtl/usec_compare_timer.sv
module usec_compare_timer #(
  parameter int unsigned      CLK_HZ      = 50_000_000,
  parameter int unsigned      TICK_HZ     = 1_000_000,
  parameter logic [63:0]      RESET_COUNT = 64'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [3:0]  irq
);
  localparam int unsigned DIV = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;
  localparam int unsigned PW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned NCH = 4;

  localparam logic [4:0] OFS_STAT = 5'h00;
  localparam logic [4:0] OFS_LOW  = 5'h04;
  localparam logic [4:0] OFS_HIGH = 5'h08;
  localparam logic [4:0] OFS_CMP0 = 5'h0C;

  logic [PW-1:0]  pre;
  logic           tick;
  logic [63:0]    count;
  logic [31:0]    next_low;
  logic [31:0]    cmp [NCH];
  logic [NCH-1:0] hit;
  logic [NCH-1:0] set_v;
  logic [NCH-1:0] clr_v;
  logic           wr_stat;

  assign tick     = (pre == PW'(DIV - 1));
  assign next_low = count[31:0] + 32'd1;
  assign wr_stat  = bus_en && bus_wr && (bus_addr == OFS_STAT);
  assign irq      = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
    end else if (tick) begin
      pre <= '0;
    end else begin
      pre <= pre + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= RESET_COUNT;
    end else if (tick) begin
      count <= count + 64'd1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_chan
      localparam logic [4:0] OFS = OFS_CMP0 + 5'(4 * g);

      assign set_v[g] = tick && (next_low == cmp[g]);
      assign clr_v[g] = wr_stat && bus_wdata[g];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cmp[g] <= '0;
        end else if (bus_en && bus_wr && bus_addr == OFS) begin
          cmp[g] <= bus_wdata;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hit[g] <= 1'b0;
        end else if (set_v[g]) begin
          hit[g] <= 1'b1;
        end else if (clr_v[g]) begin
          hit[g] <= 1'b0;
        end
      end

      assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[g] && !clr_v[g]) |=> hit[g]);
      assert_match_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && next_low == cmp[g]) |=> hit[g]);
      assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v[g] && !set_v[g]) |=> !hit[g]);
      assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v[g] && set_v[g]) |=> hit[g]);
      assert_flag_rises_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit[g]) |-> $past(tick));
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_STAT:         bus_rdata = {{(32 - NCH){1'b0}}, hit};
      OFS_LOW:          bus_rdata = count[31:0];
      OFS_HIGH:         bus_rdata = count[63:32];
      OFS_CMP0:         bus_rdata = cmp[0];
      OFS_CMP0 + 5'd4:  bus_rdata = cmp[1];
      OFS_CMP0 + 5'd8:  bus_rdata = cmp[2];
      OFS_CMP0 + 5'd12: bus_rdata = cmp[3];
      default:          bus_rdata = '0;
    endcase
  end

  assert_count_steps_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count == $past(count) + 64'd1));
  assert_count_holds_between_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  assert_tick_single_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (DIV > 1 && tick) |=> !tick);
  assert_low_word_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count[31:0] == 32'hFFFF_FFFF) |=> (count[63:32] == $past(count[63:32]) + 32'd1));
endmodule

// File: tb/usec_compare_timer_bench.sv
module usec_compare_timer_bench;
  localparam int unsigned CLK_HZ = 50_000_000;
  localparam int unsigned TICK_HZ = 1_000_000;
  localparam int DIV = CLK_HZ / TICK_HZ;
  localparam logic [63:0] START = 64'h0000_0001_FFFF_FFFC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  usec_compare_timer #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .RESET_COUNT(START)) u_usec_compare_timer (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic test_reset();
    logic [31:0] v;
    bus_read(5'h08, v); check(v == 32'h1, "R2 high word", v, 32'h1);
    bus_read(5'h04, v); check(v == 32'hFFFF_FFFC, "R2 low word", v, 32'hFFFF_FFFC);
    bus_read(5'h00, v); check(v == 32'h0, "R2 status", v, 0);
    check(irq == 4'h0, "R2 irq", irq, 0);
    for (int n = 0; n < 4; n++) begin
      bus_read(5'(12 + 4 * n), v); check(v == 32'h0, "R2 compare", v, 0);
    end
  endtask

  task automatic test_wrap();
    logic [31:0] v;
    repeat (5 * DIV) @(negedge clk);
    bus_read(5'h04, v); check(v == 32'h1, "R3 low after wrap", v, 1);
    bus_read(5'h08, v); check(v == 32'h2, "R3 high carry", v, 2);
    bus_read(5'h00, v); check(v == 32'hF, "R5 R10 all compares at zero matched", v, 32'hF);
    check(irq == 4'hF, "R8 irq follows status", irq, 4'hF);
  endtask

  task automatic test_clear();
    logic [31:0] v;
    bus_write(5'h00, 32'h0);
    bus_read(5'h00, v); check(v == 32'hF, "R6 zero write keeps flags", v, 32'hF);
    bus_write(5'h00, 32'h5);
    bus_read(5'h00, v); check(v == 32'hA, "R6 partial clear", v, 32'hA);
    check(irq == 4'hA, "R8 irq after partial clear", irq, 4'hA);
    bus_write(5'h00, 32'hA);
    bus_read(5'h00, v); check(v == 32'h0, "R6 full clear", v, 0);
  endtask

  task automatic test_compare_rw();
    logic [31:0] v;
    for (int n = 0; n < 4; n++) bus_write(5'(12 + 4 * n), 32'hA5A5_0000 + 32'(n * 17));
    for (int n = 0; n < 4; n++) begin
      bus_read(5'(12 + 4 * n), v);
      check(v == 32'hA5A5_0000 + 32'(n * 17), "R4 compare readback", v, 32'hA5A5_0000 + 32'(n * 17));
    end
  endtask

  task automatic test_rate();
    logic [31:0] a, b;
    bus_read(5'h04, a);
    repeat (10 * DIV - 1) @(negedge clk);
    bus_read(5'h04, b);
    check(b - a == 32'd10, "R1 ten ticks in ten periods", b - a, 10);
    bus_read(5'h04, a);
    repeat (DIV - 1) @(negedge clk);
    bus_read(5'h04, b);
    check(b - a == 32'd1, "R1 one tick per period", b - a, 1);
  endtask

  task automatic test_match();
    logic [31:0] v, cur;
    logic        prev;
    bit          seen;
    for (int n = 0; n < 4; n++) begin
      bus_read(5'h04, v);
      bus_write(5'(12 + 4 * n), v + 32'd3);
      seen = 0;
      prev = irq[n];
      for (int k = 0; k < 5 * DIV && !seen; k++) begin
        prev = irq[n];
        bus_read(5'h04, cur);
        if (cur == v + 32'd3) begin
          seen = 1;
          check(irq[n] == 1'b1 && prev == 1'b0, "R5 flag rises with match tick", {prev, irq[n]}, 2'b01);
          check((irq & ~(4'b1 << n)) == 4'h0, "R5 other channels quiet", irq, 4'b1 << n);
        end
      end
      check(seen, "R5 match value reached", seen, 1);
      repeat (2 * DIV) @(negedge clk);
      check(irq[n] == 1'b1, "R5 flag sticky", irq[n], 1);
      bus_write(5'h00, 32'(1 << n));
      check(irq[n] == 1'b0, "R6 flag cleared by one", irq[n], 0);
    end
  endtask

  task automatic test_set_wins();
    logic [31:0] prev, cur;
    bus_read(5'h04, prev);
    cur = prev;
    while (cur == prev) bus_read(5'h04, cur);
    bus_write(5'h0C, cur + 32'd1);
    repeat (DIV - 3) @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 5'h00; bus_wdata = 32'h1;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
    bus_addr = 5'h04;
    #1;
    check(bus_rdata == cur + 32'd1, "R7 clear landed on match tick", bus_rdata, cur + 32'd1);
    check(irq[0] == 1'b1, "R7 set beats clear", irq[0], 1);
    bus_write(5'h00, 32'h1);
    check(irq[0] == 1'b0, "R6 clear after collision", irq[0], 0);
  endtask

  task automatic test_ignored();
    logic [31:0] h, l, h2, l2;
    bus_read(5'h08, h);
    bus_read(5'h04, l);
    bus_write(5'h04, 32'h1234_5678);
    bus_write(5'h08, 32'h0000_DEAD);
    bus_read(5'h08, h2);
    bus_read(5'h04, l2);
    check(h2 == h, "R9 high word write ignored", h2, h);
    check(l2 - l <= 32'd1, "R9 low word write ignored", l2, l);
    bus_read(5'h1C, h2); check(h2 == 32'h0, "R10 unused offset", h2, 0);
    bus_read(5'h05, h2); check(h2 == 32'h0, "R10 unaligned offset", h2, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_wrap();
    test_clear();
    test_compare_rw();
    test_rate();
    test_match();
    test_set_wins();
    test_ignored();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule